// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs from its own slow clock, apart from the bus clock that software uses to program it. A 16-bit command word written to the command slot acts as a key. One key unlocks the two configuration slots (clock divider and reload value), one locks them again, one restarts the count from the reload value, and one starts the watchdog. Any other command word is discarded.

Each configuration write is held in a bus-side shadow register and handed to the watchdog clock domain through a toggle handshake. While the handshake is in flight, a per-register busy output stays high and further writes to that register are dropped. Once started, the down-counter decrements once per divided tick. When it runs out it raises a one-cycle reset request and loads the reload value again. Software has to issue the reload key often enough to prevent this.

Top module: `keyed_wdt`

## Requirements
- R1: After both resets, `div_busy`, `rld_busy` and `wdt_reset_req` are low and the counter is stopped.
- R2: Write slot 1 (divider) and slot 2 (reload) are accepted only after command 0x5555 has been written to slot 0. Command 0x0000 locks them again. A locked write leaves the busy flag low and does not change the timeout.
- R3: A slot-0 command other than 0x5555, 0x0000, 0xAAAA or 0xCCCC changes nothing: the lock state, the timeout and the running state are all unaffected.
- R4: Bits [2:0] of a divider write select a divide ratio of 4 << code for codes 0 to 5. Codes 6 and 7 both select 256.
- R5: Only bits [11:0] of a reload write are kept. With reload value N ≥ 1 and divide ratio D, the reset requests are N·D watchdog cycles apart. With N = 0 they are D cycles apart.
- R6: A busy flag is high on the bus cycle after its register accepts a write, and it falls once the value has reached the watchdog domain. A write to that register while its flag is high is dropped.
- R7: Command 0xAAAA restarts the count from the reload value and clears the divider phase. Issuing it faster than the timeout keeps the reset request low.
- R8: No reset request occurs before command 0xCCCC. Once started the counter cannot be stopped, and a repeated 0xCCCC has no effect.
- R9: When the count runs out, `wdt_reset_req` is high for exactly one watchdog cycle, and the counter reloads on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_sel | input | 2 | Slot select: 0 command, 1 divider, 2 reload |
| wr_data | input | 16 | Write data |
| div_busy | output | 1 | Divider update in flight |
| rld_busy | output | 1 | Reload update in flight |
| wd_clk | input | 1 | Watchdog clock |
| wd_rst_n | input | 1 | Synchronous active-low reset, watchdog domain |
| wdt_reset_req | output | 1 | One-cycle reset request |

## Verification
A busy flag is due on the first bus edge after an accepted write, so the bench samples it at the falling edge that follows the write. Its clearing depends on two synchronisers and the clock ratio, so the bench polls for it within a bounded window rather than at a fixed cycle. Reset-request timing is measured as the number of watchdog cycles between two consecutive pulses, counted at falling edges of the watchdog clock. This interval does not depend on handshake latency. After each reconfiguration the bench discards the first interval, because that interval may straddle the moment the reload reached the counter.

// File: rtl/wdg_pkg.sv
// Shared constants and helpers for the keyed watchdog.
// Assumes a 16-bit command word and a 3-bit divider code.
package wdg_pkg;
    localparam int CMD_W   = 16;
    localparam int DCODE_W = 3;
    localparam int RLD_W   = 12;
    localparam int PDIV_W  = 8;

    localparam logic [CMD_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [CMD_W-1:0] KEY_LOCK   = 16'h0000;
    localparam logic [CMD_W-1:0] KEY_RELOAD = 16'hAAAA;
    localparam logic [CMD_W-1:0] KEY_START  = 16'hCCCC;

    typedef enum logic [1:0] {
        SEL_CMD = 2'd0,
        SEL_DIV = 2'd1,
        SEL_RLD = 2'd2
    } wsel_e;

    // Last prescaler count for a divider code: (4 << code) - 1, saturating at 255.
    function automatic logic [PDIV_W-1:0] div_last(input logic [DCODE_W-1:0] code);
        logic [3:0] sh;
        sh = (code >= 3'd6) ? 4'd8 : ({1'b0, code} + 4'd2);
        return PDIV_W'((9'd1 << sh) - 9'd1);
    endfunction
endpackage

// File: rtl/wdg_sync.sv
// Multi-stage synchroniser for a single level or toggle signal.
// Assumes the input is a slowly changing level from another clock domain.
module wdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_key_dec.sv
// Bus-side key decoder: tracks the unlock state and the sticky start request,
// toggles a reload event, and qualifies configuration writes.
// Assumes a single-cycle wr_en per write.
module wdg_key_dec
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CMD_W-1:0] wr_data,
    output logic             unlocked,
    output logic             start_lvl,
    output logic             reload_tgl,
    output logic             div_wr,
    output logic             rld_wr
);
    logic unlocked_q, start_q, reload_q;
    logic cmd_hit;

    assign cmd_hit = wr_en && (wr_sel == SEL_CMD);

    // Decode command keys; unknown words fall through untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
            start_q    <= 1'b0;
            reload_q   <= 1'b0;
        end else if (cmd_hit) begin
            case (wr_data)
                KEY_UNLOCK: unlocked_q <= 1'b1;
                KEY_LOCK:   unlocked_q <= 1'b0;
                KEY_RELOAD: reload_q   <= ~reload_q;
                KEY_START:  start_q    <= 1'b1;
                default:    ;
            endcase
        end
    end

    assign unlocked   = unlocked_q;
    assign start_lvl  = start_q;
    assign reload_tgl = reload_q;
    assign div_wr     = wr_en && (wr_sel == SEL_DIV) && unlocked_q;
    assign rld_wr     = wr_en && (wr_sel == SEL_RLD) && unlocked_q;
endmodule

// File: rtl/wdg_cfg_xfer.sv
// Carries one configuration register from the bus domain to the watchdog domain
// through a toggle request/acknowledge handshake, and reports busy meanwhile.
// Assumes the shadow is stable while busy, which the write gate guarantees.
module wdg_cfg_xfer #(
    parameter int          W         = 12,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         bus_clk,
    input  logic         bus_rst_n,
    input  logic         wr_ok,
    input  logic [W-1:0] wr_val,
    output logic         busy,
    input  logic         wd_clk,
    input  logic         wd_rst_n,
    output logic [W-1:0] wd_val
);
    logic [W-1:0] shadow_q, wd_val_q;
    logic         req_q, ack_q, req_s, ack_s;

    assign busy = req_q ^ ack_s;

    // Capture a new value and raise a request when idle.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            shadow_q <= RESET_VAL;
            req_q    <= 1'b0;
        end else if (wr_ok && !busy) begin
            shadow_q <= wr_val;
            req_q    <= ~req_q;
        end
    end

    wdg_sync #(.STAGES(2)) u_req_sync (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(req_q), .q(req_s)
    );

    // Take the stable shadow into the watchdog domain and acknowledge.
    always_ff @(posedge wd_clk) begin
        if (!wd_rst_n) begin
            wd_val_q <= RESET_VAL;
            ack_q    <= 1'b0;
        end else if (req_s != ack_q) begin
            wd_val_q <= shadow_q;
            ack_q    <= req_s;
        end
    end

    wdg_sync #(.STAGES(2)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_q), .q(ack_s)
    );

    assign wd_val = wd_val_q;

    // R6: the value in flight never moves while busy.
    a_r6_shadow_frozen: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy |=> $stable(shadow_q));
endmodule

// File: rtl/wdg_core.sv
// Watchdog-domain prescaler and down-counter with the reset request output.
// Assumes start and reload inputs are already synchronised to wd_clk.
module wdg_core
    import wdg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_s,
    input  logic               reload_tgl_s,
    input  logic [DCODE_W-1:0] div_code,
    input  logic [RLD_W-1:0]   rld_val,
    output logic               reset_req
);
    logic [PDIV_W-1:0] pcnt_q, plast;
    logic [RLD_W-1:0]  cnt_q;
    logic              run_q, tgl_prev_q, req_q;
    logic              reload_evt, tick;

    assign plast      = div_last(div_code);
    assign reload_evt = reload_tgl_s ^ tgl_prev_q;
    assign tick       = run_q && (pcnt_q >= plast);

    // Prescale, count down, and fire a one-cycle request on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q     <= '0;
            cnt_q      <= '1;
            run_q      <= 1'b0;
            tgl_prev_q <= 1'b0;
            req_q      <= 1'b0;
        end else begin
            tgl_prev_q <= reload_tgl_s;
            run_q      <= run_q | start_s;
            req_q      <= 1'b0;
            if (reload_evt) begin
                cnt_q  <= rld_val;
                pcnt_q <= '0;
            end else if (tick) begin
                pcnt_q <= '0;
                if (cnt_q <= RLD_W'(1)) begin
                    req_q <= 1'b1;
                    cnt_q <= rld_val;
                end else begin
                    cnt_q <= cnt_q - RLD_W'(1);
                end
            end else if (run_q) begin
                pcnt_q <= pcnt_q + PDIV_W'(1);
            end
        end
    end

    assign reset_req = req_q;

    // R9: the request is a single watchdog-cycle pulse.
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    // R8: no request before the watchdog runs.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !reset_req);
    // R8: once running it never stops.
    a_r8_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q);
endmodule

// File: rtl/keyed_wdt.sv
// Top level of the key-protected watchdog: bus-side key decode and
// configuration shadows, clock-domain crossing, watchdog-domain counter.
// Assumes bus_clk and wd_clk are unrelated; each domain has its own reset.
module keyed_wdt
    import wdg_pkg::*;
(
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    output logic        div_busy,
    output logic        rld_busy,
    input  logic        wd_clk,
    input  logic        wd_rst_n,
    output logic        wdt_reset_req
);
    logic               unlocked, start_lvl, reload_tgl, div_wr, rld_wr;
    logic               start_s, reload_s;
    logic [DCODE_W-1:0] div_code;
    logic [RLD_W-1:0]   rld_val;

    wdg_key_dec u_keys (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .unlocked(unlocked), .start_lvl(start_lvl),
        .reload_tgl(reload_tgl), .div_wr(div_wr), .rld_wr(rld_wr)
    );

    wdg_cfg_xfer #(.W(DCODE_W), .RESET_VAL('0)) u_div_xfer (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_ok(div_wr),
        .wr_val(wr_data[DCODE_W-1:0]), .busy(div_busy),
        .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .wd_val(div_code)
    );

    wdg_cfg_xfer #(.W(RLD_W), .RESET_VAL('1)) u_rld_xfer (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_ok(rld_wr),
        .wr_val(wr_data[RLD_W-1:0]), .busy(rld_busy),
        .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .wd_val(rld_val)
    );

    wdg_sync #(.STAGES(2)) u_start_sync (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(start_lvl), .q(start_s)
    );

    wdg_sync #(.STAGES(2)) u_reload_sync (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(reload_tgl), .q(reload_s)
    );

    wdg_core u_core (
        .clk(wd_clk), .rst_n(wd_rst_n), .start_s(start_s),
        .reload_tgl_s(reload_s), .div_code(div_code), .rld_val(rld_val),
        .reset_req(wdt_reset_req)
    );

    // R2: while locked, an idle divider channel cannot turn busy.
    a_r2_locked_div_idle: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!unlocked && !div_busy) |=> !div_busy);
    // R2: same for the reload channel.
    a_r2_locked_rld_idle: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!unlocked && !rld_busy) |=> !rld_busy);
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    logic        bus_clk = 1'b0, wd_clk = 1'b0;
    logic        bus_rst_n = 1'b0, wd_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        div_busy, rld_busy, wdt_reset_req;
    int          n_chk = 0, n_fail = 0;

    always #4  bus_clk = ~bus_clk;
    always #20 wd_clk  = ~wd_clk;

    keyed_wdt i_keyed_wdt (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .div_busy(div_busy), .rld_busy(rld_busy),
        .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .wdt_reset_req(wdt_reset_req)
    );

    // {divider code, reload write data, expected period in wd cycles}
    localparam int NV = 7;
    localparam int VEC [NV][3] = '{
        '{0, 3, 12}, '{1, 'hF002, 16}, '{2, 1, 16}, '{0, 0, 4},
        '{3, 1, 32}, '{6, 1, 256}, '{7, 1, 256}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge bus_clk);
            if (!div_busy && !rld_busy) begin ok = 1'b1; break; end
        end
    endtask

    // Watchdog cycles between two consecutive request pulses; -1 on timeout.
    task automatic measure(output int p);
        bit seen = 1'b0;
        p = -1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge wd_clk);
            if (wdt_reset_req) begin seen = 1'b1; break; end
        end
        if (seen) begin
            for (int n = 1; n <= 4000; n++) begin
                @(negedge wd_clk);
                if (wdt_reset_req) begin p = n; break; end
            end
        end
    endtask

    task automatic configure(input int code, input int rld, input string req);
        bit ok;
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wait_idle(ok);
        check(ok, req, int'(ok), 1);
        wr(2'd2, 16'(rld));
        wait_idle(ok);
        check(ok, req, int'(ok), 1);
        wr(2'd0, 16'hAAAA);
    endtask

    initial begin
        repeat (190000) @(posedge bus_clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int p, pulses;
        bit ok;
        repeat (4) @(posedge wd_clk);
        @(negedge bus_clk); bus_rst_n = 1'b1;
        @(negedge wd_clk);  wd_rst_n  = 1'b1;
        @(negedge bus_clk);
        // R1 reset state
        check(!div_busy, "R1", int'(div_busy), 0);
        check(!rld_busy, "R1", int'(rld_busy), 0);
        check(!wdt_reset_req, "R1", int'(wdt_reset_req), 0);

        // R2 locked writes are dropped
        wr(2'd1, 16'd3);
        check(!div_busy, "R2", int'(div_busy), 0);
        wr(2'd2, 16'd5);
        check(!rld_busy, "R2", int'(rld_busy), 0);
        // R3 a near-miss unlock word does not unlock
        wr(2'd0, 16'h5556);
        wr(2'd2, 16'd5);
        check(!rld_busy, "R3", int'(rld_busy), 0);

        // R6 busy rises right after an accepted write
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        check(div_busy, "R6", int'(div_busy), 1);
        wait_idle(ok);
        check(ok, "R6", int'(ok), 1);
        wr(2'd2, 16'd3);
        check(rld_busy, "R6", int'(rld_busy), 1);
        wait_idle(ok);
        wr(2'd0, 16'hAAAA);

        // R8 nothing happens before start
        pulses = 0;
        repeat (300) begin @(negedge wd_clk); if (wdt_reset_req) pulses++; end
        check(pulses == 0, "R8", pulses, 0);

        // R8 R9 start and measure the period
        wr(2'd0, 16'hCCCC);
        measure(p); measure(p);
        check(p == 12, "R9", p, 12);

        // R4 R5 table of divider/reload settings
        for (int v = 0; v < NV; v++) begin
            configure(VEC[v][0], VEC[v][1], "R4");
            measure(p); measure(p);
            check(p == VEC[v][2], (v == 1) ? "R5" : "R4", p, VEC[v][2]);
        end

        // R6 write while busy is dropped
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd2);
        wr(2'd1, 16'd6);
        wait_idle(ok);
        wr(2'd2, 16'd1);
        wait_idle(ok);
        wr(2'd0, 16'hAAAA);
        measure(p); measure(p);
        check(p == 16, "R6", p, 16);

        // R2 lock key closes access again
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'd7);
        check(!rld_busy, "R2", int'(rld_busy), 0);
        wr(2'd0, 16'hAAAA);
        measure(p); measure(p);
        check(p == 16, "R2", p, 16);

        // R3 R8 unknown word and a repeated start change nothing
        wr(2'd0, 16'h1234);
        wr(2'd0, 16'hCCCC);
        measure(p); measure(p);
        check(p == 16, "R3", p, 16);

        // R7 regular reloads keep the request low
        configure(2, 50, "R7");
        repeat (10) @(negedge wd_clk);
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            repeat (200) begin @(negedge wd_clk); if (wdt_reset_req) pulses++; end
            wr(2'd0, 16'hAAAA);
        end
        check(pulses == 0, "R7", pulses, 0);
        measure(p);
        check(p == 800, "R7", p, 800);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule